// File: doc/BRIEF.md
# Paged Register Window Bridge

This bridge lets a local requester reach any location in a device's 32-bit internal address space through a small memory-mapped region. The region holds three windows. Window A is fixed at region offset 0x00 and is 0x58 bytes long. Window C follows at offset 0x58 and is 8 bytes long. The 32 bytes from 0x60 to 0x7F are not a window and are never produced. Window B starts at region offset 0x80 and spans one power-of-two page of the internal space. The bases of A and C are loaded from parameters at reset. The base of B moves.

For each request the bridge checks that the address is legal and tests the windows in the order A, B, C. It then turns the internal address into a region offset and issues one access on the downstream bus port. If no window covers the address, the bridge first relocates window B. It issues one configuration write that carries the page-aligned base, then performs the access through B.

A string request moves a number of consecutive bytes, one bus access per byte. Each byte goes through its own window decode, so B can move partway through a string. The bridge accepts no other request until the string has finished.

Top module: `swb_bridge`

## Requirements
- R1: A request whose address lies in `[A base, A base + 0x58)` is served through window A at offset `addr - A base`. Window A is tested before B and C, so an address covered by both A and B goes through A.
- R2: If A does not cover the address and `[B base, B base + 2^B_LOG2)` does, the offset is `addr - B base + 0x80`. Window B is tested before C.
- R3: If only `[C base, C base + 8)` covers the address, the offset is `addr - C base + 0x58`.
- R4: If no window covers a legal address, exactly one configuration write is issued before the bus access. It carries the address with its low B_LOG2 bits cleared, and B takes that base. The access then uses the B offset. Later addresses in the same page cause no configuration write.
- R5: An address at or above 0xC0000000, or below LOW_BASE, completes with `done_err`=1. It causes no bus access and no configuration write. The addresses LOW_BASE and 0xBFFFFFFF are legal.
- R6: When `io_mode` is 1 at acceptance, `bus_offs` carries only bits [7:0] of the computed offset, with the upper bits zero.
- R7: Size encoding is 0 = byte, 1 = halfword, 2 = word. A single read returns `bus_rdata` masked to the access width in `done_rdata`. A single write passes `req_wdata`, the size and `bus_write`=1 to the bus.
- R8: A string request with `req_string`=1 moves `req_count` bytes at consecutive addresses, each as a byte access decoded on its own. On writes, byte k is lane k mod 4 of `req_wdata` and goes on `bus_wdata[7:0]`. On reads, each byte shifts in at bits [31:24] of `done_rdata`, so after four bytes the byte at the start address sits in [7:0].
- R9: A string stops at the first illegal byte address and reports `done_err`, with no further access. A count of 0 completes with no access and no error.
- R10: `req_ready` is low from acceptance until `done`, including for the whole of a string. `done` is a single-cycle pulse, once per request.
- R11: After reset, `req_ready`=1, `done`=0, `bus_valid`=0 and `cfg_valid`=0.
- R12: While `bus_valid` is high and `bus_ready` is low, `bus_valid` stays high and `bus_offs` is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| io_mode | input | 1 | Truncate the bus offset to 8 bits for this request |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Bridge idle and able to take a request |
| req_addr | input | 32 | Internal address (start address for a string) |
| req_size | input | 2 | Access width: 0 byte, 1 halfword, 2 word |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 32 | Write data |
| req_string | input | 1 | Byte-string transfer |
| req_count | input | CNT_W | Byte count for a string |
| done | output | 1 | Completion pulse |
| done_rdata | output | 32 | Read result |
| done_err | output | 1 | Address rejected |
| cfg_valid | output | 1 | Configuration write of the new B base |
| cfg_ready | input | 1 | Configuration write accepted |
| cfg_data | output | 32 | New page-aligned B base |
| bus_valid | output | 1 | Bus access request |
| bus_ready | input | 1 | Bus access completes this cycle |
| bus_offs | output | 32 | Offset inside the mapped region |
| bus_size | output | 2 | Access width on the bus |
| bus_write | output | 1 | Bus access direction |
| bus_wdata | output | 32 | Bus write data |
| bus_rdata | input | 32 | Bus read data, right-justified, valid with bus_ready |

## Verification
The hardest case to reach from the ports is a relocation of window B partway through a string, right after a byte that hit B near the top of its page. The bench gets there by first parking B far away, so that the first byte of the string also misses. The string's start address sits one byte below a 64 KiB boundary, so two relocations happen inside one string. The A-over-B and B-over-C priority cases are staged the same way: reset leaves B overlapping A, and a later miss moves B onto C's page.

// File: rtl/swb_pkg.sv
// Shared types for the paged register window bridge.
// Assumes a 32-bit internal address space and 32-bit data.
package swb_pkg;
    localparam int SWB_AW = 32;
    localparam int SWB_DW = 32;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2
    } swb_size_e;

    typedef enum logic [1:0] {
        WIN_NONE = 2'd0,
        WIN_A    = 2'd1,
        WIN_B    = 2'd2,
        WIN_C    = 2'd3
    } swb_win_e;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_LOOK = 3'd1,
        ST_CFG  = 3'd2,
        ST_BUS  = 3'd3,
        ST_FIN  = 3'd4
    } swb_state_e;
endpackage

// File: rtl/swb_decode.sv
// Window decoder: purely combinational.
// Given an internal address and the three window bases, it reports
// legality, the winning window (priority A, B, C), the region offset,
// and the page-aligned base that window B would need to cover the address.
// Assumes wide accesses fit inside the window holding their first byte.
module swb_decode
    import swb_pkg::*;
#(
    parameter int                A_SIZE      = 'h58,
    parameter int                C_SIZE      = 8,
    parameter int                MIRROR_SIZE = 'h20,
    parameter int                B_LOG2      = 16,
    parameter logic [SWB_AW-1:0] LOW_BASE    = 32'hA000_0000,
    parameter logic [SWB_AW-1:0] HIGH_LIMIT  = 32'hC000_0000
) (
    input  logic [SWB_AW-1:0] addr,
    input  logic [SWB_AW-1:0] a_base,
    input  logic [SWB_AW-1:0] b_base,
    input  logic [SWB_AW-1:0] c_base,
    output logic              illegal,
    output swb_win_e          win,
    output logic [SWB_AW-1:0] offs,
    output logic [SWB_AW-1:0] miss_base
);
    localparam int                AW     = SWB_AW;
    localparam logic [AW:0]       SPAN_A = (AW+1)'(A_SIZE);
    localparam logic [AW:0]       SPAN_C = (AW+1)'(C_SIZE);
    localparam logic [AW:0]       SPAN_B = (AW+1)'(1) << B_LOG2;
    localparam logic [AW-1:0]     OFF_C  = AW'(A_SIZE);
    localparam logic [AW-1:0]     OFF_B  = AW'(A_SIZE + C_SIZE + MIRROR_SIZE);
    localparam logic [AW-1:0]     B_MASK = AW'((SPAN_B - 1'b1));

    logic [AW:0] addr_x;
    logic        hit_a, hit_b, hit_c;

    // Range tests done one bit wider so base + size cannot wrap.
    always_comb begin
        addr_x = {1'b0, addr};
        hit_a  = (addr_x >= {1'b0, a_base}) && (addr_x < ({1'b0, a_base} + SPAN_A));
        hit_b  = (addr_x >= {1'b0, b_base}) && (addr_x < ({1'b0, b_base} + SPAN_B));
        hit_c  = (addr_x >= {1'b0, c_base}) && (addr_x < ({1'b0, c_base} + SPAN_C));
    end

    // Legality check against the fixed ceiling and the configured floor.
    assign illegal   = (addr >= HIGH_LIMIT) || (addr < LOW_BASE);
    assign miss_base = addr & ~B_MASK;

    // Priority selection and offset formation.
    always_comb begin
        win  = WIN_NONE;
        offs = '0;
        if (hit_a) begin
            win  = WIN_A;
            offs = addr - a_base;
        end else if (hit_b) begin
            win  = WIN_B;
            offs = addr - b_base + OFF_B;
        end else if (hit_c) begin
            win  = WIN_C;
            offs = addr - c_base + OFF_C;
        end
    end
endmodule

// File: rtl/swb_ctrl.sv
// Request sequencer for the window bridge.
// Accepts one request, walks it through legality check, optional B
// relocation (one configuration write) and the bus access, then pulses
// done. A string request loops byte by byte and keeps the bridge busy.
// Assumes bus_rdata is valid in the cycle bus_ready is high.
module swb_ctrl
    import swb_pkg::*;
#(
    parameter int                CNT_W      = 8,
    parameter int                B_LOG2     = 16,
    parameter logic [SWB_AW-1:0] B_BASE_RST = 32'hB000_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              io_mode,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [SWB_AW-1:0] req_addr,
    input  logic [1:0]        req_size,
    input  logic              req_write,
    input  logic [SWB_DW-1:0] req_wdata,
    input  logic              req_string,
    input  logic [CNT_W-1:0]  req_count,
    output logic              done,
    output logic [SWB_DW-1:0] done_rdata,
    output logic              done_err,
    output logic              cfg_valid,
    input  logic              cfg_ready,
    output logic [SWB_AW-1:0] cfg_data,
    output logic              bus_valid,
    input  logic              bus_ready,
    output logic [SWB_AW-1:0] bus_offs,
    output logic [1:0]        bus_size,
    output logic              bus_write,
    output logic [SWB_DW-1:0] bus_wdata,
    input  logic [SWB_DW-1:0] bus_rdata,
    // decoder interface
    output logic [SWB_AW-1:0] cur_addr,
    output logic [SWB_AW-1:0] b_base,
    input  logic              dec_illegal,
    input  swb_win_e          dec_win,
    input  logic [SWB_AW-1:0] dec_offs,
    input  logic [SWB_AW-1:0] dec_miss_base
);
    localparam int AW = SWB_AW;
    localparam int DW = SWB_DW;

    swb_state_e       state_q;
    logic [AW-1:0]    addr_q, b_base_q;
    swb_size_e        size_q;
    logic             write_q, string_q, io_q, err_q;
    logic [DW-1:0]    wdata_q, rdata_q, rd_masked;
    logic [CNT_W-1:0] remain_q;
    logic [1:0]       lane_q;

    assign cur_addr = addr_q;
    assign b_base   = b_base_q;

    // Port outputs decoded from the state.
    assign req_ready  = (state_q == ST_IDLE);
    assign done       = (state_q == ST_FIN);
    assign done_rdata = rdata_q;
    assign done_err   = err_q;
    assign cfg_valid  = (state_q == ST_CFG);
    assign cfg_data   = dec_miss_base;
    assign bus_valid  = (state_q == ST_BUS);
    assign bus_write  = write_q;

    // Bus offset, narrowed to the low byte in I/O mode.
    assign bus_offs = io_q ? {{(AW-8){1'b0}}, dec_offs[7:0]} : dec_offs;

    // Bus width and write lane: strings always move single bytes.
    always_comb begin
        if (string_q) begin
            bus_size  = SZ_BYTE;
            bus_wdata = {{(DW-8){1'b0}}, wdata_q[lane_q*8 +: 8]};
        end else begin
            bus_size  = size_q;
            bus_wdata = wdata_q;
        end
    end

    // Read data trimmed to the requested width.
    always_comb begin
        case (size_q)
            SZ_BYTE: rd_masked = {{(DW-8){1'b0}},  bus_rdata[7:0]};
            SZ_HALF: rd_masked = {{(DW-16){1'b0}}, bus_rdata[15:0]};
            default: rd_masked = bus_rdata;
        endcase
    end

    // Main sequencer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            addr_q   <= '0;
            b_base_q <= B_BASE_RST;
            size_q   <= SZ_BYTE;
            write_q  <= 1'b0;
            string_q <= 1'b0;
            io_q     <= 1'b0;
            err_q    <= 1'b0;
            wdata_q  <= '0;
            rdata_q  <= '0;
            remain_q <= '0;
            lane_q   <= '0;
        end else begin
            case (state_q)
                ST_IDLE: if (req_valid) begin
                    addr_q   <= req_addr;
                    size_q   <= swb_size_e'(req_size);
                    write_q  <= req_write;
                    string_q <= req_string;
                    io_q     <= io_mode;
                    wdata_q  <= req_wdata;
                    remain_q <= req_count;
                    lane_q   <= '0;
                    err_q    <= 1'b0;
                    rdata_q  <= '0;
                    state_q  <= ST_LOOK;
                end
                ST_LOOK: begin
                    if (string_q && remain_q == '0) begin
                        state_q <= ST_FIN;
                    end else if (dec_illegal) begin
                        err_q   <= 1'b1;
                        state_q <= ST_FIN;
                    end else if (dec_win == WIN_NONE) begin
                        state_q <= ST_CFG;
                    end else begin
                        state_q <= ST_BUS;
                    end
                end
                ST_CFG: if (cfg_ready) begin
                    b_base_q <= dec_miss_base;
                    state_q  <= ST_LOOK;
                end
                ST_BUS: if (bus_ready) begin
                    if (string_q) begin
                        if (!write_q) rdata_q <= {bus_rdata[7:0], rdata_q[DW-1:8]};
                        addr_q   <= addr_q + 1'b1;
                        lane_q   <= lane_q + 1'b1;
                        remain_q <= remain_q - 1'b1;
                        state_q  <= (remain_q == CNT_W'(1)) ? ST_FIN : ST_LOOK;
                    end else begin
                        if (!write_q) rdata_q <= rd_masked;
                        state_q <= ST_FIN;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    AST_BUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid && !bus_ready |=> bus_valid && $stable(bus_offs)); // R12
    AST_CFG_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_valid |-> cfg_data[B_LOG2-1:0] == '0); // R4
    AST_MISS_LANDS_B: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_valid && cfg_ready |=> dec_win == WIN_B); // R4
    AST_ONE_PORT: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_valid && bus_valid)); // R4
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done && req_ready); // R10
    AST_ERR_NO_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid |-> !dec_illegal); // R5
endmodule

// File: rtl/swb_bridge.sv
// Top of the paged register window bridge.
// Holds the fixed window bases (loaded from parameters at reset) and
// connects the window decoder to the request sequencer.
// Assumes the A and C windows do not need to move at run time.
module swb_bridge
    import swb_pkg::*;
#(
    parameter int                CNT_W       = 8,
    parameter int                A_SIZE      = 'h58,
    parameter int                C_SIZE      = 8,
    parameter int                MIRROR_SIZE = 'h20,
    parameter int                B_LOG2      = 16,
    parameter logic [SWB_AW-1:0] LOW_BASE    = 32'hA000_0000,
    parameter logic [SWB_AW-1:0] HIGH_LIMIT  = 32'hC000_0000,
    parameter logic [SWB_AW-1:0] A_BASE_RST  = 32'hB000_0000,
    parameter logic [SWB_AW-1:0] B_BASE_RST  = 32'hB000_0000,
    parameter logic [SWB_AW-1:0] C_BASE_RST  = 32'hB003_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              io_mode,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [31:0]       req_addr,
    input  logic [1:0]        req_size,
    input  logic              req_write,
    input  logic [31:0]       req_wdata,
    input  logic              req_string,
    input  logic [CNT_W-1:0]  req_count,
    output logic              done,
    output logic [31:0]       done_rdata,
    output logic              done_err,
    output logic              cfg_valid,
    input  logic              cfg_ready,
    output logic [31:0]       cfg_data,
    output logic              bus_valid,
    input  logic              bus_ready,
    output logic [31:0]       bus_offs,
    output logic [1:0]        bus_size,
    output logic              bus_write,
    output logic [31:0]       bus_wdata,
    input  logic [31:0]       bus_rdata
);
    logic [SWB_AW-1:0] a_base_q, c_base_q, cur_addr, b_base;
    logic [SWB_AW-1:0] dec_offs, dec_miss_base;
    logic              dec_illegal;
    swb_win_e          dec_win;

    // Fixed window bases, set on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_base_q <= A_BASE_RST;
            c_base_q <= C_BASE_RST;
        end
    end

    swb_decode #(
        .A_SIZE(A_SIZE), .C_SIZE(C_SIZE), .MIRROR_SIZE(MIRROR_SIZE),
        .B_LOG2(B_LOG2), .LOW_BASE(LOW_BASE), .HIGH_LIMIT(HIGH_LIMIT)
    ) u_dec (
        .addr(cur_addr), .a_base(a_base_q), .b_base(b_base), .c_base(c_base_q),
        .illegal(dec_illegal), .win(dec_win), .offs(dec_offs),
        .miss_base(dec_miss_base)
    );

    swb_ctrl #(
        .CNT_W(CNT_W), .B_LOG2(B_LOG2), .B_BASE_RST(B_BASE_RST)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .io_mode(io_mode),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_size(req_size), .req_write(req_write), .req_wdata(req_wdata),
        .req_string(req_string), .req_count(req_count),
        .done(done), .done_rdata(done_rdata), .done_err(done_err),
        .cfg_valid(cfg_valid), .cfg_ready(cfg_ready), .cfg_data(cfg_data),
        .bus_valid(bus_valid), .bus_ready(bus_ready), .bus_offs(bus_offs),
        .bus_size(bus_size), .bus_write(bus_write), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .cur_addr(cur_addr), .b_base(b_base), .dec_illegal(dec_illegal),
        .dec_win(dec_win), .dec_offs(dec_offs), .dec_miss_base(dec_miss_base)
    );
endmodule

// File: tb/tb_swb_bridge.sv
`timescale 1ns/1ps
module tb_swb_bridge;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        io_mode = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0;
    logic [1:0]  req_size = '0;
    logic        req_write = 1'b0;
    logic [31:0] req_wdata = '0;
    logic        req_string = 1'b0;
    logic [7:0]  req_count = '0;
    logic        done, done_err;
    logic [31:0] done_rdata;
    logic        cfg_valid, cfg_ready;
    logic [31:0] cfg_data;
    logic        bus_valid, bus_ready, bus_write;
    logic [31:0] bus_offs, bus_wdata, bus_rdata;
    logic [1:0]  bus_size;

    int errors = 0;
    int checks = 0;

    always #10 clk = ~clk;   // 50 MHz

    swb_bridge dut (
        .clk(clk), .rst_n(rst_n), .io_mode(io_mode),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_size(req_size), .req_write(req_write), .req_wdata(req_wdata),
        .req_string(req_string), .req_count(req_count),
        .done(done), .done_rdata(done_rdata), .done_err(done_err),
        .cfg_valid(cfg_valid), .cfg_ready(cfg_ready), .cfg_data(cfg_data),
        .bus_valid(bus_valid), .bus_ready(bus_ready), .bus_offs(bus_offs),
        .bus_size(bus_size), .bus_write(bus_write), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata)
    );

    // Bus and config responders: one wait cycle before each acceptance.
    logic bphase, cphase;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bphase <= 1'b0;
            cphase <= 1'b0;
        end else begin
            bphase <= bus_valid && !bphase;
            cphase <= cfg_valid && !cphase;
        end
    end
    assign bus_ready = bus_valid && bphase;
    assign cfg_ready = cfg_valid && cphase;

    function automatic logic [31:0] model(input logic [31:0] o);
        return {o[7:0] ^ 8'h3C, o[7:0], o[15:8], o[7:0] ^ 8'hC3};
    endfunction
    assign bus_rdata = model(bus_offs);

    // Transaction monitor.
    int          bus_n = 0;
    int          cfg_n = 0;
    logic [31:0] last_cfg;
    logic [31:0] log_offs [16];
    logic [31:0] log_wd   [16];
    logic [1:0]  log_size [16];
    logic        log_wr   [16];
    always @(posedge clk) begin
        if (bus_valid && bus_ready) begin
            log_offs[bus_n % 16] <= bus_offs;
            log_wd[bus_n % 16]   <= bus_wdata;
            log_size[bus_n % 16] <= bus_size;
            log_wr[bus_n % 16]   <= bus_write;
            bus_n <= bus_n + 1;
        end
        if (cfg_valid && cfg_ready) begin
            last_cfg <= cfg_data;
            cfg_n    <= cfg_n + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // Issue one request and wait for its completion pulse.
    task automatic do_req(input logic [31:0] a, input logic [1:0] sz, input bit wr,
                          input logic [31:0] wd, input bit io, input bit str,
                          input logic [7:0] cnt, output logic [31:0] rd, output bit er);
        bit busy_ok = 1'b1;
        int n = 0;
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_size = sz; req_write = wr;
        req_wdata = wd; io_mode = io; req_string = str; req_count = cnt;
        @(negedge clk);
        req_valid = 1'b0;
        while (!done && n < 2000) begin
            if (req_ready) busy_ok = 1'b0;
            @(negedge clk);
            n++;
        end
        chk(n < 2000, "R10", "completion seen", n, 0);
        chk(busy_ok, "R10", "ready low while busy", {31'b0, busy_ok}, 1);
        rd = done_rdata;
        er = done_err;
        @(negedge clk);
        chk(!done && req_ready, "R10", "single done pulse", {30'b0, done, req_ready}, 1);
    endtask

    typedef struct packed {
        logic [31:0] addr;
        logic [1:0]  size;
        logic        wr;
        logic [31:0] wdata;
        logic        io;
        logic        err;
        logic        cfg;
        logic [31:0] cfg_base;
        logic [31:0] offs;
    } vec_t;

    // R1/R2/R3/R4/R5/R6/R7 walk; B starts at 0xB000_0000, A at 0xB000_0000, C at 0xB003_0000.
    localparam vec_t VECS [15] = '{
        '{32'hB000_0010, 2'd2, 1'b0, 32'h0,         1'b0, 1'b0, 1'b0, 32'h0,         32'h10},    // R1 A over B
        '{32'hB000_0100, 2'd1, 1'b0, 32'h0,         1'b0, 1'b0, 1'b0, 32'h0,         32'h180},   // R2
        '{32'hB003_0004, 2'd0, 1'b1, 32'h0000_00A5, 1'b0, 1'b0, 1'b0, 32'h0,         32'h5C},    // R3
        '{32'hB003_0007, 2'd0, 1'b0, 32'h0,         1'b0, 1'b0, 1'b0, 32'h0,         32'h5F},    // R3 top
        '{32'hB005_1234, 2'd2, 1'b0, 32'h0,         1'b0, 1'b0, 1'b1, 32'hB005_0000, 32'h12B4},  // R4
        '{32'hB005_0010, 2'd2, 1'b0, 32'h0,         1'b0, 1'b0, 1'b0, 32'h0,         32'h90},    // R4 no repeat
        '{32'hB000_0057, 2'd0, 1'b0, 32'h0,         1'b0, 1'b0, 1'b0, 32'h0,         32'h57},    // R1 top
        '{32'hB000_0058, 2'd2, 1'b1, 32'hDEAD_BEEF, 1'b0, 1'b0, 1'b1, 32'hB000_0000, 32'hD8},    // R4 past A
        '{32'hC000_0000, 2'd2, 1'b0, 32'h0,         1'b0, 1'b1, 1'b0, 32'h0,         32'h0},     // R5 ceiling
        '{32'h9FFF_FFFC, 2'd2, 1'b0, 32'h0,         1'b0, 1'b1, 1'b0, 32'h0,         32'h0},     // R5 floor
        '{32'hA000_0000, 2'd0, 1'b0, 32'h0,         1'b0, 1'b0, 1'b1, 32'hA000_0000, 32'h80},    // R5 floor legal
        '{32'hA000_0104, 2'd2, 1'b0, 32'h0,         1'b1, 1'b0, 1'b0, 32'h0,         32'h84},    // R6
        '{32'hB003_0008, 2'd0, 1'b0, 32'h0,         1'b0, 1'b0, 1'b1, 32'hB003_0000, 32'h88},    // R3 past C
        '{32'hB003_0004, 2'd2, 1'b0, 32'h0,         1'b0, 1'b0, 1'b0, 32'h0,         32'h84},    // R2 B over C
        '{32'hBFFF_FFFE, 2'd1, 1'b1, 32'h0000_1234, 1'b0, 1'b0, 1'b1, 32'hBFFF_0000, 32'h1007E}  // R5 ceiling legal
    };

    initial begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=expired expected=finished");
        finish_run();
    end

    initial begin
        logic [31:0] rd, exp_rd;
        bit er;
        int b0, c0;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk(req_ready, "R11", "req_ready", {31'b0, req_ready}, 1);
        chk(!done && !bus_valid && !cfg_valid, "R11", "idle outputs",
            {29'b0, done, bus_valid, cfg_valid}, 0);

        foreach (VECS[i]) begin
            b0 = bus_n; c0 = cfg_n;
            do_req(VECS[i].addr, VECS[i].size, VECS[i].wr, VECS[i].wdata, VECS[i].io,
                   1'b0, 8'd0, rd, er);
            chk(er == VECS[i].err, "R5", "error flag", {31'b0, er}, {31'b0, VECS[i].err});
            if (VECS[i].err) begin
                chk(bus_n == b0 && cfg_n == c0, "R5", "no access on reject",
                    bus_n - b0 + cfg_n - c0, 0);
            end else begin
                chk(cfg_n - c0 == int'(VECS[i].cfg), "R4", "config write count",
                    cfg_n - c0, {31'b0, VECS[i].cfg});
                if (VECS[i].cfg)
                    chk(last_cfg == VECS[i].cfg_base, "R4", "new B base", last_cfg, VECS[i].cfg_base);
                chk(bus_n - b0 == 1, "R7", "one bus access", bus_n - b0, 1);
                chk(log_offs[b0 % 16] == VECS[i].offs, "R1 R2 R3 R6", "offset",
                    log_offs[b0 % 16], VECS[i].offs);
                chk(log_size[b0 % 16] == VECS[i].size && log_wr[b0 % 16] == VECS[i].wr,
                    "R7", "size and direction", {29'b0, log_wr[b0 % 16], log_size[b0 % 16]},
                    {29'b0, VECS[i].wr, VECS[i].size});
                if (VECS[i].wr) begin
                    chk(log_wd[b0 % 16] == VECS[i].wdata, "R7", "write data",
                        log_wd[b0 % 16], VECS[i].wdata);
                end else begin
                    exp_rd = model(VECS[i].offs);
                    if (VECS[i].size == 2'd0) exp_rd &= 32'hFF;
                    else if (VECS[i].size == 2'd1) exp_rd &= 32'hFFFF;
                    chk(rd == exp_rd, "R7", "read data", rd, exp_rd);
                end
            end
        end

        // R8 string write crossing a page: B sits at 0xBFFF_0000, so two moves.
        b0 = bus_n; c0 = cfg_n;
        do_req(32'hB003_FFFF, 2'd2, 1'b1, 32'h4433_2211, 1'b0, 1'b1, 8'd3, rd, er);
        chk(!er, "R8", "string write no error", {31'b0, er}, 0);
        chk(bus_n - b0 == 3, "R8", "three byte accesses", bus_n - b0, 3);
        chk(cfg_n - c0 == 2, "R8", "B moved twice in string", cfg_n - c0, 2);
        chk(last_cfg == 32'hB004_0000, "R8", "last B base", last_cfg, 32'hB004_0000);
        chk(log_offs[b0 % 16] == 32'h1007F, "R8", "byte0 offset", log_offs[b0 % 16], 32'h1007F);
        chk(log_offs[(b0+1) % 16] == 32'h80, "R8", "byte1 offset", log_offs[(b0+1) % 16], 32'h80);
        chk(log_offs[(b0+2) % 16] == 32'h81, "R8", "byte2 offset", log_offs[(b0+2) % 16], 32'h81);
        chk(log_wd[b0 % 16] == 32'h11 && log_wd[(b0+1) % 16] == 32'h22 &&
            log_wd[(b0+2) % 16] == 32'h33, "R8", "byte lanes",
            log_wd[(b0+2) % 16], 32'h33);
        chk(log_size[(b0+1) % 16] == 2'd0, "R8", "byte size", {30'b0, log_size[(b0+1) % 16]}, 0);

        // R8 string read of four bytes through B.
        b0 = bus_n;
        do_req(32'hB004_0010, 2'd2, 1'b0, 32'h0, 1'b0, 1'b1, 8'd4, rd, er);
        exp_rd = {8'h93 ^ 8'hC3, 8'h92 ^ 8'hC3, 8'h91 ^ 8'hC3, 8'h90 ^ 8'hC3};
        chk(rd == exp_rd, "R8", "string read packing", rd, exp_rd);
        chk(bus_n - b0 == 4, "R8", "four byte reads", bus_n - b0, 4);

        // R9 string running into the ceiling.
        b0 = bus_n; c0 = cfg_n;
        do_req(32'hBFFF_FFFF, 2'd0, 1'b0, 32'h0, 1'b0, 1'b1, 8'd2, rd, er);
        chk(er, "R9", "string stops with error", {31'b0, er}, 1);
        chk(bus_n - b0 == 1, "R9", "only first byte accessed", bus_n - b0, 1);
        chk(cfg_n - c0 == 1 && last_cfg == 32'hBFFF_0000, "R9", "one move before stop",
            last_cfg, 32'hBFFF_0000);

        // R9 zero-length string.
        b0 = bus_n; c0 = cfg_n;
        do_req(32'hB000_0000, 2'd0, 1'b1, 32'hFF, 1'b0, 1'b1, 8'd0, rd, er);
        chk(!er, "R9", "zero count no error", {31'b0, er}, 0);
        chk(bus_n == b0 && cfg_n == c0, "R9", "zero count no access",
            bus_n - b0 + cfg_n - c0, 0);

        finish_run();
    end
endmodule